// File: doc/BRIEF.md
# Decoded-Strobe Serial Configuration Register

This block holds a six-bit configuration word for a stepper-motor control path. It has no clock or data pin of its own for loading. The word is loaded serially through the control lines that the motor logic already uses. When all four phase lines are driven low together, the block makes one load strobe. The bit that is loaded is the exclusive-OR of the two auxiliary mode lines.

All six lines cross into the system clock domain through a two-stage synchronizer. A strobe is a single system-clock pulse made on the edge where the all-low condition appears. Holding the lines low therefore loads only one bit.

The stored word is also presented as named fields:
- a two-bit current reference level,
- a two-bit open-loop duty code,
- a chopping-frequency select bit,
- a spare decode-option bit.

An active-low asynchronous reset clears the word.

Top module: `scfg_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, `cfg_word` is all zeros.
- R2: A bit is loaded only when all four `phase_in` bits are low at the same time. If any single phase bit is high, nothing is loaded.
- R3: The loaded bit equals `aux_a` XOR `aux_b`, sampled at the same time as the all-low condition.
- R4: Each all-low episode loads exactly one bit, however long it lasts. A further load needs the phase lines to leave the all-low state and then return to it.
- R5: A new bit enters at `cfg_word[0]`. Each older bit moves one position up, and the bit held in `cfg_word[5]` is discarded.
- R6: The field outputs are taken from fixed positions: `cur_ref` = `cfg_word[1:0]`, `duty_code` = `cfg_word[3:2]`, `freq_sel` = `cfg_word[4]`, `opt_bit` = `cfg_word[5]`.
- R7: When no load occurs, the word holds its value, even when the aux lines change.
- R8: When the inputs change and are then held steady, the updated word appears on the third rising clock edge after the change. Two of those edges are synchronizer stages and one is the register.
- R9: If the all-low condition is already present when reset is released, it does not load a bit. A load needs a not-all-low state to be seen first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_in | input | 4 | Phase control lines; all low together gives a load strobe |
| aux_a | input | 1 | First auxiliary mode line |
| aux_b | input | 1 | Second auxiliary mode line |
| cfg_word | output | 6 | Stored configuration word |
| cur_ref | output | 2 | Current reference level field |
| duty_code | output | 2 | Open-loop duty field |
| freq_sel | output | 1 | Chopping-frequency select |
| opt_bit | output | 1 | Spare decode-option bit |

## Verification
The bench targets three strobe faults:
- If the strobe were a level rather than an edge, a long all-low hold would fill the word with repeated bits.
- If the decode were missing one phase bit, a pattern with one line high would load a bit when it should not.
- If the strobe history reset to "not all low", an all-low level present at reset release would load a stray bit.

The bench also checks the data path:
- It walks all four aux combinations, which catches an OR or AND used in place of the XOR.
- It shifts seven bits, which shows the shift direction and that the oldest bit is dropped.
- It checks the word one cycle before the update as well as at the update, so an extra or missing synchronizer stage is seen.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam int CFG_BITS   = 6;
  localparam int PHASE_BITS = 4;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic       opt;
    logic       freq;
    logic [1:0] duty;
    logic [1:0] cur_ref;
  } cfg_fields_t;

  function automatic logic serial_bit(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic cfg_fields_t split_word(input logic [CFG_BITS-1:0] w);
    cfg_fields_t f;
    f.cur_ref = w[1:0];
    f.duty    = w[3:2];
    f.freq    = w[4];
    f.opt     = w[5];
    return f;
  endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/scfg_strobe.sv
module scfg_strobe #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_s,
  output logic               strobe
);

  function automatic logic phase_all_low(input logic [PHASE_W-1:0] p);
    return ~|p;
  endfunction

  logic all_low;
  logic all_low_q;

  assign all_low = phase_all_low(phase_s);

  // The history flop resets to "already low", so a level that is present at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_low_q <= 1'b1;
    else        all_low_q <= all_low;
  end

  assign strobe = all_low & ~all_low_q;

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_no_strobe_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !strobe);

endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [CFG_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[CFG_W-2:0], din};
  end

  assert_shift_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[CFG_W-1:1] == $past(word[CFG_W-2:0])) && (word[0] == $past(din)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word == '0));

endmodule

// File: rtl/scfg_top.sv
module scfg_top
  import scfg_pkg::*;
#(
  parameter int CFG_W   = CFG_BITS,
  parameter int PHASE_W = PHASE_BITS,
  parameter int SYNC_N  = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic             aux_a,
  input  logic             aux_b,
  output logic [CFG_W-1:0] cfg_word,
  output logic [1:0]       cur_ref,
  output logic [1:0]       duty_code,
  output logic             freq_sel,
  output logic             opt_bit
);

  localparam int IN_W = PHASE_W + 2;

  logic [IN_W-1:0]    raw_in;
  logic [IN_W-1:0]    sync_in;
  logic [PHASE_W-1:0] phase_s;
  logic               aux_a_s;
  logic               aux_b_s;
  logic               load_strobe;
  logic               load_bit;
  cfg_fields_t        fields;

  assign raw_in = {phase_in, aux_a, aux_b};

  scfg_sync #(.W(IN_W), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  assign phase_s = sync_in[IN_W-1:2];
  assign aux_a_s = sync_in[1];
  assign aux_b_s = sync_in[0];

  scfg_strobe #(.PHASE_W(PHASE_W)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_s (phase_s),
    .strobe  (load_strobe)
  );

  assign load_bit = serial_bit(aux_a_s, aux_b_s);

  scfg_shift #(.CFG_W(CFG_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (load_strobe),
    .din      (load_bit),
    .word     (cfg_word)
  );

  assign fields    = split_word(cfg_word);
  assign cur_ref   = fields.cur_ref;
  assign duty_code = fields.duty;
  assign freq_sel  = fields.freq;
  assign opt_bit   = fields.opt;

  assert_strobe_all_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> (phase_s == '0));

  assert_xor_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> cfg_word[0] == ($past(aux_a_s) != $past(aux_b_s)));

endmodule

// File: tb/scfg_top_tb.sv
module scfg_top_tb;

  typedef struct {
    int          due;
    logic [5:0]  exp;
    string       tag;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] phase_in = 4'hF;
  logic       aux_a = 0;
  logic       aux_b = 0;
  logic [5:0] cfg_word;
  logic [1:0] cur_ref, duty_code;
  logic       freq_sel, opt_bit;

  int         cyc = 0;
  int         checks = 0;
  int         failures = 0;
  logic [5:0] model = '0;
  item_t      sb_q[$];
  bit         done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scfg_top u_dut (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .aux_a(aux_a), .aux_b(aux_b),
    .cfg_word(cfg_word), .cur_ref(cur_ref), .duty_code(duty_code),
    .freq_sel(freq_sel), .opt_bit(opt_bit)
  );

  task automatic push(input int due, input logic [5:0] e, input string tag);
    item_t it;
    it.due = due; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares the word and its fields (R6 positions) when an item falls due.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [11:0] act, expv;
      it = sb_q.pop_front();
      act  = {cfg_word, opt_bit, freq_sel, duty_code, cur_ref};
      expv = {it.exp, it.exp[5], it.exp[4], it.exp[3:2], it.exp[1:0]};
      checks++;
      if (act !== expv) begin
        failures++;
        $display("FAIL %s/R6 cycle %0d actual=%b expected=%b", it.tag, cyc, act, expv);
      end
    end
  end

  // One load: raise the phase lines, then drop all four with the given aux values.
  task automatic load_bit(input logic a, input logic b, input string tag);
    @(negedge clk);
    phase_in = 4'hF;
    repeat (4) @(negedge clk);
    phase_in = 4'h0; aux_a = a; aux_b = b;
    push(cyc + 2, model, "R8");
    model = {model[4:0], a ^ b};
    push(cyc + 3, model, tag);
    repeat (5) @(negedge clk);
    phase_in = 4'hF;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model = '0;
    repeat (3) @(negedge clk);
    push(cyc, model, "R1");
    rst_n = 1;
    @(negedge clk);
    push(cyc, model, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    push(cyc, 6'h00, "R1");
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3: all aux combinations
    load_bit(0, 0, "R3");
    load_bit(1, 0, "R3");
    load_bit(0, 1, "R3");
    load_bit(1, 1, "R3");
    load_bit(1, 0, "R3");

    // R5: seven more bits push out the oldest
    load_bit(1, 0, "R5");
    load_bit(0, 0, "R5");
    load_bit(1, 1, "R5");
    load_bit(0, 1, "R5");
    load_bit(0, 0, "R5");
    load_bit(1, 0, "R5");
    load_bit(0, 1, "R5");

    // R4: hold all-low for a long time with aux toggling
    load_bit(1, 0, "R4");
    phase_in = 4'h0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      aux_a = i[0]; aux_b = 1'b0;
    end
    push(cyc + 3, model, "R4");
    repeat (4) @(negedge clk);
    phase_in = 4'hF;

    // R2 and R7: three lines low, one high, aux xor = 1
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      phase_in = 4'hF;
      repeat (3) @(negedge clk);
      phase_in = 4'h1 << k; aux_a = 1; aux_b = 0;
      repeat (6) @(negedge clk);
      push(cyc, model, "R2");
      aux_a = 0; aux_b = 1;
      repeat (4) @(negedge clk);
      push(cyc, model, "R7");
    end

    // R1: reset in the middle of use
    do_reset();

    // R9: all-low held through reset release
    @(negedge clk);
    phase_in = 4'h0; aux_a = 1; aux_b = 0;
    rst_n = 0;
    model = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (8) @(negedge clk);
    push(cyc, model, "R9");
    load_bit(1, 0, "R9");

    repeat (6) @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule